// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter Stage

This block is a four-bit synchronous up-counter stage that is meant to be chained. Two elaboration-time choices shape each instance. The first is the count modulus: decade, which counts 0 to 9, or full binary, which counts 0 to 15. The second is how the active-low clear acts: it can force the state to zero at once, or only on the next rising clock edge.

Each rising edge applies the highest-priority request present. The order is clear, then parallel load, then count, then hold. The stage advances only when both of its count enables are high. One of these enables also gates the terminal-count output. To form a wider counter, feed that output into the gating enable of the next stage. The carry then passes down the chain within one clock period, and every stage changes on the same edge.

In decade mode a load can leave the stage at 10 through 15, which are not decimal digits. From these values the stage steps up by one on each count, and 15 steps to 0. It is therefore back in the normal cycle after at most six counts.

Top module: `sync_counter_stage`

## Requirements
- R1: The state changes only on a rising clock edge, except for an immediate clear in the asynchronous variant. A load request or a count request leaves the outputs unchanged until that edge.
- R2: With MODULUS = 10, counting runs 0,1,…,9. From 9 the next count gives 0.
- R3: With MODULUS = 16, counting runs 0,1,…,15. From 15 the next count gives 0.
- R4: With ASYNC_CLEAR = 1, a low on `clr_n` forces `q` to 0 without waiting for a clock edge. While `clr_n` stays low, `q` stays 0 whatever the clock, load and enable inputs do.
- R5: With ASYNC_CLEAR = 0, a low on `clr_n` does not change `q` before the next rising edge. At that edge `q` becomes 0, even when a load or a count is also requested.
- R6: When `clr_n` is high and `load_n` is low, the next rising edge copies `din` into `q`. The enable inputs have no effect on this load.
- R7: When `clr_n` and `load_n` are both high, `q` goes up by one on a rising edge only if `en_p` and `en_t` are both 1. If either enable is 0, `q` holds its value.
- R8: `tc` is 1 exactly when `q` equals MODULUS−1 and `en_t` is 1. It is 0 at all other times, including when `en_t` is 0.
- R9: With MODULUS = 10, a count from any state 10 through 14 gives the state plus one. A count from 15 gives 0.
- R10: Two stages can be chained into an 8-bit counter. The lower stage's `tc` drives the upper stage's `en_t`, and both stages share `en_p`. The upper stage then advances on exactly the edges where the lower stage is at its terminal value and `en_t` of the lower stage is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state is updated on the rising edge |
| clr_n | input | 1 | Active-low clear; acts at once or on the edge, depending on ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Value copied into the state on a load |
| en_p | input | 1 | Count enable that does not affect `tc` |
| en_t | input | 1 | Count enable that also gates `tc`; takes the carry in a chain |
| q | output | WIDTH | Counter state |
| tc | output | 1 | Terminal count: state is MODULUS−1 and `en_t` is high |

## Verification
The bound checker looks at every clock edge of every stage. It checks that the outcome matches the priority of clear, load, count and hold. It also checks the wrap at the terminal value, the single-step walk out of the illegal decade states, and the decode and gating of `tc`. Some behaviours involve more than one edge, more than one stage, or time between edges, so only the bench scenarios can show them. These are the immediate clear in the asynchronous variant, the absence of any change before the edge in the synchronous variant, and carry propagation across a chained pair through full wraps of the 8-bit value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_act_e;

  // Priority: clear (when edge-qualified), load, count, hold.
  function automatic cnt_act_e pick_action(
    input logic clr_n,
    input logic load_n,
    input logic en_p,
    input logic en_t,
    input logic clear_on_edge
  );
    if (clear_on_edge && !clr_n) return ACT_CLEAR;
    if (!load_n)                 return ACT_LOAD;
    if (en_p && en_t)            return ACT_COUNT;
    return ACT_HOLD;
  endfunction

endpackage

// File: rtl/cnt_action_sel.sv
module cnt_action_sel #(
  parameter bit SYNC_CLEAR = 1'b0
) (
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              en_p,
  input  logic              en_t,
  output cnt_pkg::cnt_act_e act
);
  assign act = cnt_pkg::pick_action(clr_n, load_n, en_p, en_t, SYNC_CLEAR);
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  cnt_pkg::cnt_act_e act,
  input  logic [WIDTH-1:0]  q,
  input  logic [WIDTH-1:0]  din,
  output logic [WIDTH-1:0]  nxt
);
  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] MAX_V  = '1;

  // One count step: the terminal value and the all-ones value go to zero,
  // any other value (legal or not) goes up by one.
  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] v);
    if (v == TERM_V || v == MAX_V) return '0;
    return v + WIDTH'(1);
  endfunction

  always_comb begin
    unique case (act)
      cnt_pkg::ACT_CLEAR: nxt = '0;
      cnt_pkg::ACT_LOAD:  nxt = din;
      cnt_pkg::ACT_COUNT: nxt = advance(q);
      default:            nxt = q;
    endcase
  end
endmodule

// File: rtl/cnt_term_decode.sv
module cnt_term_decode #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             at_term,
  output logic             tc
);
  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(MODULUS - 1);
  assign at_term = (q == TERM_V);
  assign tc      = at_term & en_t;
endmodule

// File: rtl/sync_counter_stage.sv
module sync_counter_stage #(
  parameter int WIDTH       = 4,
  parameter int MODULUS     = 10,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam bit SYNC_CLEAR = !ASYNC_CLEAR;

  cnt_pkg::cnt_act_e act;
  logic [WIDTH-1:0]  nxt;
  logic [WIDTH-1:0]  state_q;
  logic              at_term;

  cnt_action_sel #(.SYNC_CLEAR(SYNC_CLEAR)) sel_i (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .act    (act)
  );

  cnt_next_state #(.WIDTH(WIDTH), .MODULUS(MODULUS)) nxt_i (
    .act (act),
    .q   (state_q),
    .din (din),
    .nxt (nxt)
  );

  generate
    if (ASYNC_CLEAR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= '0;
        else        state_q <= nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        state_q <= nxt;
      end
    end
  endgenerate

  cnt_term_decode #(.WIDTH(WIDTH), .MODULUS(MODULUS)) tc_i (
    .q       (state_q),
    .en_t    (en_t),
    .at_term (at_term),
    .tc      (tc)
  );

  assign q = state_q;

endmodule

// File: rtl/sync_counter_stage_chk.sv
module sync_counter_stage_chk #(
  parameter int WIDTH       = 4,
  parameter int MODULUS     = 10,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] q,
  input logic             tc
);
  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(MODULUS - 1);
  localparam logic [WIDTH-1:0] MAX_V  = '1;

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  generate
    if (ASYNC_CLEAR) begin : g_async
      p_async_clear_r4: assert property (@(posedge clk) disable iff (!started)
        !clr_n |-> q == '0);
    end else begin : g_sync
      p_sync_clear_r5: assert property (@(posedge clk) disable iff (!started)
        $past(!clr_n) |-> q == '0);
    end
  endgenerate

  p_load_r6: assert property (@(posedge clk) disable iff (!started)
    (clr_n && $past(clr_n && !load_n)) |-> q == $past(din));

  p_hold_r7: assert property (@(posedge clk) disable iff (!started)
    (clr_n && $past(clr_n && load_n && !(en_p && en_t))) |-> q == $past(q));

  p_step_r7: assert property (@(posedge clk) disable iff (!started)
    (clr_n && $past(clr_n && load_n && en_p && en_t && q != TERM_V && q != MAX_V))
      |-> q == $past(q) + WIDTH'(1));

  p_wrap_r2_r3: assert property (@(posedge clk) disable iff (!started)
    (clr_n && $past(clr_n && load_n && en_p && en_t && q == TERM_V)) |-> q == '0);

  p_illegal_top_r9: assert property (@(posedge clk) disable iff (!started)
    (clr_n && $past(clr_n && load_n && en_p && en_t && q == MAX_V)) |-> q == '0);

  p_tc_set_r8: assert property (@(posedge clk) disable iff (!started)
    tc |-> (en_t && q == TERM_V));

  p_tc_gate_r8: assert property (@(posedge clk) disable iff (!started)
    (en_t && q == TERM_V) |-> tc);

endmodule

bind sync_counter_stage sync_counter_stage_chk #(
  .WIDTH(WIDTH), .MODULUS(MODULUS), .ASYNC_CLEAR(ASYNC_CLEAR)
) chk_i (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
  .en_p(en_p), .en_t(en_t), .q(q), .tc(tc)
);

// File: tb/sync_counter_stage_tb_top.sv
`timescale 1ns/1ps
module sync_counter_stage_tb_top;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic [7:0] din8 = 8'h00;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;

  logic [3:0] qa_lo, qa_hi, qb_lo, qb_hi;
  logic       tca_lo, tca_hi, tcb_lo, tcb_hi;

  int nchecks = 0;
  int errors  = 0;

  logic [3:0] ma_lo = 4'd0, ma_hi = 4'd0, mb_lo = 4'd0, mb_hi = 4'd0;

  always #2 clk = ~clk;

  // Pair A: decade stages with immediate clear (BCD 00..99)
  sync_counter_stage #(.WIDTH(4), .MODULUS(10), .ASYNC_CLEAR(1'b1)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din8[3:0]),
    .en_p(en_p), .en_t(en_t), .q(qa_lo), .tc(tca_lo));
  sync_counter_stage #(.WIDTH(4), .MODULUS(10), .ASYNC_CLEAR(1'b1)) dec_hi_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din8[7:4]),
    .en_p(en_p), .en_t(tca_lo), .q(qa_hi), .tc(tca_hi));

  // Pair B: binary stages with edge clear (0..255)
  sync_counter_stage #(.WIDTH(4), .MODULUS(16), .ASYNC_CLEAR(1'b0)) bin_lo_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din8[3:0]),
    .en_p(en_p), .en_t(en_t), .q(qb_lo), .tc(tcb_lo));
  sync_counter_stage #(.WIDTH(4), .MODULUS(16), .ASYNC_CLEAR(1'b0)) bin_hi_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din8[7:4]),
    .en_p(en_p), .en_t(tcb_lo), .q(qb_hi), .tc(tcb_hi));

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nchecks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, nchecks);
    $finish;
  endtask

  // Reference step for one stage, written as modular arithmetic.
  function automatic logic [3:0] ref_next(input logic [3:0] v, input logic [3:0] d,
      input logic c, input logic l, input logic ep, input logic et, input bit dec);
    logic [4:0] s;
    if (!c) return 4'd0;
    if (!l) return d;
    if (!(ep && et)) return v;
    s = {1'b0, v} + 5'd1;
    if (dec) return (s == 5'd10 || s == 5'd16) ? 4'd0 : s[3:0];
    return s[3:0];
  endfunction

  task automatic cycle(input logic c, input logic l, input logic [7:0] d,
                       input logic ep, input logic et, input string tag);
    logic tla, tlb;
    logic [3:0] na_lo, na_hi, nb_lo, nb_hi;
    @(negedge clk);
    clr_n = c; load_n = l; din8 = d; en_p = ep; en_t = et;
    #0.5;
    if (!c) begin
      ma_lo = 4'd0; ma_hi = 4'd0;
      check({qa_hi, qa_lo} == 8'd0, "R4", "immediate clear pair A",
            {qa_hi, qa_lo}, 0);
      check({qb_hi, qb_lo} == {mb_hi, mb_lo}, "R5", "no clear before edge pair B",
            {qb_hi, qb_lo}, {mb_hi, mb_lo});
    end else begin
      check({qa_hi, qa_lo} == {ma_hi, ma_lo}, "R1", "no change before edge pair A",
            {qa_hi, qa_lo}, {ma_hi, ma_lo});
      check({qb_hi, qb_lo} == {mb_hi, mb_lo}, "R1", "no change before edge pair B",
            {qb_hi, qb_lo}, {mb_hi, mb_lo});
    end
    tla = (ma_lo == 4'd9) && et;
    tlb = (mb_lo == 4'd15) && et;
    na_lo = ref_next(ma_lo, d[3:0], c, l, ep, et, 1'b1);
    na_hi = ref_next(ma_hi, d[7:4], c, l, ep, tla, 1'b1);
    nb_lo = ref_next(mb_lo, d[3:0], c, l, ep, et, 1'b0);
    nb_hi = ref_next(mb_hi, d[7:4], c, l, ep, tlb, 1'b0);
    ma_lo = na_lo; ma_hi = na_hi; mb_lo = nb_lo; mb_hi = nb_hi;
    @(posedge clk);
    #0.5;
    check({qa_hi, qa_lo} == {ma_hi, ma_lo}, tag, "pair A state",
          {qa_hi, qa_lo}, {ma_hi, ma_lo});
    check({qb_hi, qb_lo} == {mb_hi, mb_lo}, tag, "pair B state",
          {qb_hi, qb_lo}, {mb_hi, mb_lo});
    tla = (ma_lo == 4'd9) && et;
    tlb = (mb_lo == 4'd15) && et;
    check({tca_hi, tca_lo} == {(ma_hi == 4'd9) && tla, tla}, "R8", "pair A tc",
          {tca_hi, tca_lo}, {(ma_hi == 4'd9) && tla, tla});
    check({tcb_hi, tcb_lo} == {(mb_hi == 4'd15) && tlb, tlb}, "R8", "pair B tc",
          {tcb_hi, tcb_lo}, {(mb_hi == 4'd15) && tlb, tlb});
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    // Reset state: clear held low across edges, tc low with en_t low
    cycle(1'b0, 1'b1, 8'h00, 1'b0, 1'b0, "R5");
    cycle(1'b0, 1'b0, 8'h55, 1'b1, 1'b1, "R4");

    // Full sweep: binary pair wraps 255->0, decade pair wraps 99->0 twice
    for (int i = 0; i < 260; i++) cycle(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R10");

    // Enables: either low holds (R7), en_t low also kills tc (R8)
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R7");
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R7");

    // Load wins over count, then count on
    cycle(1'b1, 1'b0, 8'h37, 1'b1, 1'b1, "R6");
    cycle(1'b1, 1'b0, 8'h89, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R2");
    // Hold at terminal with en_t toggled (R8)
    cycle(1'b1, 1'b0, 8'h99, 1'b1, 1'b1, "R6");
    cycle(1'b1, 1'b1, 8'h00, 1'b1, 1'b0, "R8");
    cycle(1'b1, 1'b1, 8'h00, 1'b0, 1'b1, "R8");
    cycle(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R2");
    // Binary wrap of a lone nibble and cascade into upper
    cycle(1'b1, 1'b0, 8'h0E, 1'b1, 1'b1, "R6");
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R3");

    // Illegal decade values: every start 10..15 in both nibbles
    for (int s = 10; s < 16; s++) begin
      cycle(1'b1, 1'b0, {4'(s), 4'(s)}, 1'b1, 1'b1, "R6");
      for (int i = 0; i < 8; i++) cycle(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R9");
    end

    // Clear beats load and count in both styles
    cycle(1'b1, 1'b0, 8'h47, 1'b1, 1'b1, "R6");
    cycle(1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, "R5");
    cycle(1'b1, 1'b0, 8'hF9, 1'b1, 1'b1, "R6");
    cycle(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R4");
    cycle(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R4");
    for (int i = 0; i < 12; i++) cycle(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R10");

    finish_run();
  end

endmodule